// File: doc/BRIEF.md
# DMA Descriptor Configuration Checker

This block watches the transfer descriptor of whichever DMA channel is currently being serviced, together with the priority values of all channels and the arbitration mode. It reports each kind of configuration fault at the moment the engine would actually use the faulty setting.

Address alignment faults and duplicate-priority faults are checked when a channel activates. A misaligned scatter/gather descriptor pointer is checked only when a major loop completes with scatter/gather enabled. A mismatched link-enable bit between the current and starting iteration fields is checked only when a minor loop completes with minor-loop linking enabled.

Each report raises a one-cycle flag for its error class. It also latches the channel number into a status register with a valid bit, and raises an error interrupt request if that channel's error interrupt is enabled. The block moves no data and makes no arbitration decisions. All of its pins are plain control and status pins; there is no streaming interface, so no back-pressure applies.

Top module: `dma_cfg_checker`

## Requirements
- R1: On an activation pulse, a source address that is not aligned to its transfer size raises `err_src_align`. The size codes are 0=1 B, 1=2 B, 2=4 B, 4=16 B and 5=32 B, and the check masks the low log2(size) address bits. The codes 3, 6 and 7 are reserved and always count as misaligned.
- R2: On an activation pulse, the destination address is checked against the destination size with the same encoding, and a fault raises `err_dst_align`.
- R3: On an activation pulse with fixed arbitration selected, any two channels holding equal priority values raise `err_prio`. With round-robin selected (`fixed_arb`=0), duplicate priorities raise nothing.
- R4: `err_sg` is raised only on a major-loop completion pulse while `sg_en`=1 and bits [4:0] of `sg_addr` are not all zero. Any other event with the same bad pointer raises nothing.
- R5: `err_link` is raised only on a minor-loop completion pulse while `link_en`=1 and `citer_elink` differs from `biter_elink`. Any other event with the same mismatch raises nothing.
- R6: The error flags are single-cycle pulses, valid in the cycle after the clock edge that samples the event. They are all zero after reset and in any cycle that follows no fault.
- R7: `err_irq` pulses together with any error flag exactly when bit `ch_id` of `err_int_en` is 1.
- R8: Any reported error loads `ch_id` into `err_ch` and sets `err_vld`, overwriting any earlier value. `err_clr` clears `err_vld` but leaves `err_ch` unchanged. An error reported in the same cycle as `err_clr` wins, so `err_vld` stays set.
- R9: An event that finds no fault leaves `err_ch` and `err_vld` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_pulse | input | 1 | Channel activation event |
| minor_done | input | 1 | Minor-loop completion event |
| major_done | input | 1 | Major-loop completion event |
| ch_id | input | CH_W | Number of the serviced channel |
| src_addr | input | AW | Source address |
| dst_addr | input | AW | Destination address |
| src_size | input | 3 | Source transfer size code |
| dst_size | input | 3 | Destination transfer size code |
| sg_en | input | 1 | Scatter/gather on completion enabled |
| sg_addr | input | AW | Scatter/gather descriptor pointer |
| link_en | input | 1 | Minor-loop channel linking enabled |
| citer_elink | input | 1 | Link-enable bit of the current iteration field |
| biter_elink | input | 1 | Link-enable bit of the starting iteration field |
| fixed_arb | input | 1 | 1 = fixed-priority arbitration |
| prio_flat | input | NCH*PW | Channel priorities; channel k occupies bits [k*PW +: PW] |
| err_int_en | input | NCH | Per-channel error interrupt enable |
| err_clr | input | 1 | Clears the status valid bit |
| err_src_align | output | 1 | Source alignment error pulse |
| err_dst_align | output | 1 | Destination alignment error pulse |
| err_prio | output | 1 | Duplicate priority error pulse |
| err_sg | output | 1 | Scatter/gather pointer error pulse |
| err_link | output | 1 | Link bit mismatch error pulse |
| err_ch | output | CH_W | Latched channel number of the last error |
| err_vld | output | 1 | Status valid |
| err_irq | output | 1 | Error interrupt request pulse |

## Verification
The hardest case to reach is a fault that is present but must stay silent because the wrong event is sampling it. Examples are a bad scatter/gather pointer during activation, a link-bit mismatch at major-loop completion, and duplicate priorities under round-robin arbitration. The stimulus holds each faulty setting constant and fires the non-matching event pulses first, then the matching one. It also collides `err_clr` with a fresh error in one cycle to probe the priority rule of the status latch.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

  typedef struct packed {
    logic src;
    logic dst;
    logic prio;
    logic sg;
    logic link;
  } cfg_err_t;

  localparam int unsigned SG_ALIGN_BITS = 5;

  function automatic logic size_code_legal(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd1) || (code == 3'd2) ||
           (code == 3'd4) || (code == 3'd5);
  endfunction

  function automatic logic [4:0] size_low_mask(input logic [2:0] code);
    logic [4:0] m;
    case (code)
      3'd0:    m = 5'b00000;
      3'd1:    m = 5'b00001;
      3'd2:    m = 5'b00011;
      3'd4:    m = 5'b01111;
      3'd5:    m = 5'b11111;
      default: m = 5'b11111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dma_align_chk.sv
module dma_align_chk
  import dma_cfg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size_code,
  output logic          misaligned
);
  localparam int unsigned LOW = 5;

  logic [LOW-1:0] low_bits;
  logic           code_ok;

  always_comb begin
    low_bits   = addr[LOW-1:0] & size_low_mask(size_code);
    code_ok    = size_code_legal(size_code);
    misaligned = !code_ok || (|low_bits);
  end

  always_comb begin
    if (size_code == 3'd0) a_byte_never_bad_r1: assert (misaligned == 1'b0);
  end
endmodule

// File: rtl/dma_prio_uniq.sv
module dma_prio_uniq #(
  parameter int unsigned NCH = 16,
  parameter int unsigned PW  = 4
) (
  input  logic [NCH*PW-1:0] prio_flat,
  output logic              dup_found
);
  logic [NCH-1:0] row_dup;

  for (genvar i = 0; i < NCH; i++) begin : g_row
    always_comb begin
      row_dup[i] = 1'b0;
      for (int j = i + 1; j < NCH; j++) begin
        if (prio_flat[i*PW +: PW] == prio_flat[j*PW +: PW]) row_dup[i] = 1'b1;
      end
    end
  end

  assign dup_found = |row_dup;
endmodule

// File: rtl/dma_err_report.sv
module dma_err_report
  import dma_cfg_pkg::*;
#(
  parameter int unsigned CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_err_t        evt_err,
  input  logic [CH_W-1:0] ch_id,
  input  logic            int_en,
  input  logic            clr,
  output cfg_err_t        flags,
  output logic [CH_W-1:0] err_ch,
  output logic            err_vld,
  output logic            err_irq
);
  logic any_err;
  assign any_err = |evt_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      err_ch  <= '0;
      err_vld <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      flags   <= evt_err;
      err_irq <= any_err && int_en;
      if (any_err) begin
        err_ch  <= ch_id;
        err_vld <= 1'b1;
      end else if (clr) begin
        err_vld <= 1'b0;
      end
    end
  end

  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (|flags));
  p_clear_drops_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_err) |=> !err_vld);
  p_error_sets_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_err |=> (err_vld && err_ch == $past(ch_id)));
  p_quiet_keeps_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_err && !clr) |=> ($stable(err_vld) && $stable(err_ch)));
endmodule

// File: rtl/dma_cfg_checker.sv
module dma_cfg_checker
  import dma_cfg_pkg::*;
#(
  parameter int unsigned NCH  = 16,
  parameter int unsigned PW   = 4,
  parameter int unsigned AW   = 32,
  parameter int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_pulse,
  input  logic            minor_done,
  input  logic            major_done,
  input  logic [CH_W-1:0] ch_id,
  input  logic [AW-1:0]   src_addr,
  input  logic [AW-1:0]   dst_addr,
  input  logic [2:0]      src_size,
  input  logic [2:0]      dst_size,
  input  logic            sg_en,
  input  logic [AW-1:0]   sg_addr,
  input  logic            link_en,
  input  logic            citer_elink,
  input  logic            biter_elink,
  input  logic            fixed_arb,
  input  logic [NCH*PW-1:0] prio_flat,
  input  logic [NCH-1:0]  err_int_en,
  input  logic            err_clr,
  output logic            err_src_align,
  output logic            err_dst_align,
  output logic            err_prio,
  output logic            err_sg,
  output logic            err_link,
  output logic [CH_W-1:0] err_ch,
  output logic            err_vld,
  output logic            err_irq
);
  logic     src_bad, dst_bad, prio_dup, int_bit;
  cfg_err_t evt_err, flags;

  dma_align_chk #(.AW(AW)) u_src_chk (
    .addr(src_addr), .size_code(src_size), .misaligned(src_bad));
  dma_align_chk #(.AW(AW)) u_dst_chk (
    .addr(dst_addr), .size_code(dst_size), .misaligned(dst_bad));
  dma_prio_uniq #(.NCH(NCH), .PW(PW)) u_prio (
    .prio_flat(prio_flat), .dup_found(prio_dup));

  always_comb begin
    evt_err.src  = act_pulse && src_bad;
    evt_err.dst  = act_pulse && dst_bad;
    evt_err.prio = act_pulse && fixed_arb && prio_dup;
    evt_err.sg   = major_done && sg_en && (|sg_addr[SG_ALIGN_BITS-1:0]);
    evt_err.link = minor_done && link_en && (citer_elink != biter_elink);
    int_bit      = err_int_en[ch_id];
  end

  dma_err_report #(.CH_W(CH_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .evt_err(evt_err), .ch_id(ch_id),
    .int_en(int_bit), .clr(err_clr), .flags(flags),
    .err_ch(err_ch), .err_vld(err_vld), .err_irq(err_irq));

  assign err_src_align = flags.src;
  assign err_dst_align = flags.dst;
  assign err_prio      = flags.prio;
  assign err_sg        = flags.sg;
  assign err_link      = flags.link;

  p_act_classes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_src_align || err_dst_align || err_prio) |-> $past(act_pulse));
  p_sg_at_major_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_sg |-> ($past(major_done) && $past(sg_en)));
  p_link_at_minor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_link |-> ($past(minor_done) && $past(link_en)));
  p_prio_needs_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_prio |-> $past(fixed_arb));
endmodule

// File: tb/dma_cfg_checker_bench.sv
`timescale 1ns/1ps
module dma_cfg_checker_bench;
  localparam int NCH = 16, PW = 4, AW = 32, CH_W = 4;

  typedef struct {
    logic [4:0]      fl;   // src,dst,prio,sg,link
    logic            irq;
    logic            vld;
    logic [CH_W-1:0] ch;
    string           tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic act_pulse = 0, minor_done = 0, major_done = 0;
  logic [CH_W-1:0] ch_id = '0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0, sg_addr = '0;
  logic [2:0] src_size = 0, dst_size = 0;
  logic sg_en = 0, link_en = 0, citer_elink = 0, biter_elink = 0, fixed_arb = 0;
  logic [NCH*PW-1:0] prio_flat;
  logic [NCH-1:0] err_int_en = '1;
  logic err_clr = 0;
  logic err_src_align, err_dst_align, err_prio, err_sg, err_link, err_vld, err_irq;
  logic [CH_W-1:0] err_ch;

  int total = 0, bad = 0;
  exp_t q[$];
  logic m_vld = 0;
  logic [CH_W-1:0] m_ch = '0;

  always #5 clk = ~clk;

  dma_cfg_checker u_dma_cfg_checker (.*);

  function automatic logic ref_mis(input logic [AW-1:0] a, input logic [2:0] s);
    case (s)
      3'd0: return 1'b0;
      3'd1: return a[0];
      3'd2: return a[1:0] != 0;
      3'd4: return a[3:0] != 0;
      3'd5: return a[4:0] != 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic ref_dup();
    for (int i = 0; i < NCH; i++)
      for (int j = 0; j < NCH; j++)
        if (i != j && prio_flat[i*PW +: PW] == prio_flat[j*PW +: PW]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic go(input string tag);
    exp_t e;
    e.fl[4] = act_pulse && ref_mis(src_addr, src_size);
    e.fl[3] = act_pulse && ref_mis(dst_addr, dst_size);
    e.fl[2] = act_pulse && fixed_arb && ref_dup();
    e.fl[1] = major_done && sg_en && (sg_addr[4:0] != 0);
    e.fl[0] = minor_done && link_en && (citer_elink != biter_elink);
    e.irq = (e.fl != 0) && err_int_en[ch_id];
    if (e.fl != 0) begin m_vld = 1; m_ch = ch_id; end
    else if (err_clr) m_vld = 0;
    e.vld = m_vld; e.ch = m_ch; e.tag = tag;
    @(posedge clk); #1;
    q.push_back(e);
    @(negedge clk);
    act_pulse = 0; minor_done = 0; major_done = 0; err_clr = 0;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      e = q.pop_front();
      got = {err_src_align, err_dst_align, err_prio, err_sg, err_link};
      total++;
      if (got !== e.fl || err_irq !== e.irq || err_vld !== e.vld || err_ch !== e.ch) begin
        bad++;
        $display("FAIL %s: got fl=%b irq=%b vld=%b ch=%0d exp fl=%b irq=%b vld=%b ch=%0d",
                 e.tag, got, err_irq, err_vld, err_ch, e.fl, e.irq, e.vld, e.ch);
      end
    end
  end

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCH; k++) prio_flat[k*PW +: PW] = PW'(k);
    repeat (3) @(negedge clk);
    total++;
    if ({err_src_align, err_dst_align, err_prio, err_sg, err_link, err_vld, err_irq} !== 7'b0) begin
      bad++; $display("FAIL R6 reset: got nonzero outputs exp all zero");
    end
    rst_n = 1;
    @(negedge clk);

    // R9: clean activation with unique priorities under fixed arbitration
    fixed_arb = 1; ch_id = 4'd3; src_addr = 32'h100; dst_addr = 32'h200;
    src_size = 3'd2; dst_size = 3'd5; act_pulse = 1; go("R9 clean act");
    // R1: 4-byte source at offset 2
    src_addr = 32'h102; act_pulse = 1; go("R1 src misaligned");
    // R1: reserved code
    src_addr = 32'h100; src_size = 3'd3; act_pulse = 1; go("R1 reserved size");
    src_size = 3'd1; src_addr = 32'h101; act_pulse = 1; go("R1 2B odd addr");
    src_addr = 32'h102; src_size = 3'd1;
    // R2: 32-byte dest at 0x10, then 16-byte OK
    ch_id = 4'd7; dst_addr = 32'h210; dst_size = 3'd5; act_pulse = 1; go("R2 dst 32B misaligned");
    dst_size = 3'd4; act_pulse = 1; go("R2 dst 16B aligned");
    // R3: duplicate priorities
    prio_flat[9*PW +: PW] = 4'd2; act_pulse = 1; go("R3 dup fixed");
    fixed_arb = 0; act_pulse = 1; go("R3 dup round robin");
    // R4: bad sg pointer at wrong events, then at major
    sg_en = 1; sg_addr = 32'h408; ch_id = 4'd5; act_pulse = 1; go("R4 sg at act ignored");
    minor_done = 1; go("R4 sg at minor ignored");
    major_done = 1; go("R4 sg at major");
    sg_en = 0; major_done = 1; go("R4 sg disabled");
    sg_en = 1; sg_addr = 32'h420; major_done = 1; go("R4 sg aligned");
    // R5: link mismatch
    link_en = 1; citer_elink = 1; biter_elink = 0; ch_id = 4'd11;
    major_done = 1; go("R5 link at major ignored");
    minor_done = 1; go("R5 link at minor");
    link_en = 0; minor_done = 1; go("R5 link disabled");
    // R7: interrupt gated off for channel 12
    err_int_en[12] = 0; ch_id = 4'd12; link_en = 1; minor_done = 1; go("R7 irq masked");
    // R8: clear, then clear colliding with error
    err_clr = 1; go("R8 clear");
    err_clr = 1; ch_id = 4'd14; minor_done = 1; go("R8 clear vs error");
    // R8 overwrite with channel 2, several classes at once
    ch_id = 4'd2; fixed_arb = 1; act_pulse = 1; minor_done = 1; go("R8 overwrite multi");
    go("R6 idle after pulse");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule